// File: doc/BRIEF.md
# Converter Operating-Mode and Ready Sequencer

This block is the control engine that sits behind the configuration registers of a sigma-delta converter. It takes the selected operating mode and configuration fields, and it takes a once-per-period conversion tick from the filter along with that period's result word. From these it decides which ticks are settling periods and which yield a usable result. It deposits results into the data register and calibration coefficients into the offset or full-scale store of the active channel. It also keeps the ready and error flags and composes the status byte.

Eight modes are sequenced:
- Continuous conversion.
- Single conversion, after which the block falls back to power-down.
- Idle, which holds the filter in reset.
- Power-down.
- Four calibrations, each of which falls back to idle when it completes.

Any restart costs a settling interval, counted in conversion periods, before the first result is usable. A restart is an accepted mode write, a configuration or IO write, or leaving power-down. In continuous mode the ready flag is raised again a fixed number of system clocks before each expected update, so that a late reader does not fetch a word that is about to change.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the mode is continuous (code 000), `rdy_o` is 1, the error flag is 0, and neither `pwr_down_o` nor `filt_rst_o` is asserted.
- R2: After any restart, the first tick is discarded and the second deposits a result. A restart is an accepted mode write to 000, 001 or 1xx, or a `cfg_wr_i` strobe. In continuous mode (000) every later tick deposits. A deposit pulses `data_ld_o` for one cycle with `data_o` equal to that tick's result.
- R3: Single mode (001) deposits on the second tick after the write and then switches to power-down (011). `rdy_o` stays 0 until `data_rd_i` is strobed.
- R4: These calibrations need two ticks: internal zero-scale (100), system offset (110), system full-scale (111), and internal full-scale (101) with gain code 0 and `ext_ref_i`=1. Internal full-scale at any other gain or reference needs four ticks. The last tick pulses `coef_we_o` with the tick's result. `coef_sel_o` is 0 (offset) for 100/110 and 1 (full-scale) for 101/111, and `coef_chan_o` carries the latched channel.
- R5: An accepted calibration write sets `rdy_o` to 1. The coefficient write clears it, and the mode becomes idle (010).
- R6: A write of 101 while gain code is 7 (highest gain) is refused. The mode, the settling count and the coefficient store are left untouched.
- R7: `rdy_o` goes to 0 on every deposit and every coefficient write. It goes to 1 on `data_rd_i`, on any accepted mode write (including entry to power-down) and on `cfg_wr_i`.
- R8: Each data deposit loads the error flag: 1 when the result is all zeros or all ones, else 0. An accepted write of a converting mode (000, 001, 1xx) clears it.
- R9: `status_o` is {ready, error, 2'b00, wide, channel}. Bit 3 (wide) is 1 when `DATA_W` > 16, and bits 2..0 hold the channel latched at the last restart.
- R10: In idle (010) and power-down (011), ticks are ignored and `filt_rst_o` is 1. `pwr_down_o` is 1 only in 011.
- R11: In continuous mode with a settled filter and `rdy_o`=0, `rdy_o` rises `PERIOD_CLKS-EARLY_CLKS+1` clocks after the tick that deposited, which is `EARLY_CLKS-1` clocks before the next expected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_i | input | 3 | Mode code written with `mode_wr_i` |
| cfg_wr_i | input | 1 | Configuration or IO register write strobe |
| chan_i | input | 3 | Channel field, latched on restart |
| gain_i | input | 3 | Gain code, 0 = unity, 7 = highest |
| ext_ref_i | input | 1 | 1 = external reference selected |
| tick_i | input | 1 | Conversion period done |
| result_i | input | DATA_W | Result word of the current tick |
| data_rd_i | input | 1 | Data register read strobe |
| data_ld_o | output | 1 | Data register load pulse |
| data_o | output | DATA_W | Word to load into the data register |
| coef_we_o | output | 1 | Coefficient write pulse |
| coef_sel_o | output | 1 | 0 = offset store, 1 = full-scale store |
| coef_chan_o | output | 3 | Channel whose coefficient is written |
| coef_o | output | DATA_W | Coefficient value |
| status_o | output | 8 | Status byte |
| rdy_o | output | 1 | 1 = no unread fresh result |
| mode_o | output | 3 | Current operating mode |
| pwr_down_o | output | 1 | Power-down request |
| filt_rst_o | output | 1 | Hold filter and modulator in reset |

## Verification
The bench checks each result at the exact cycle it is due. A tick, a write or a read sampled at one rising edge shows its whole effect at that edge: the load pulses, the flags, the mode and the status byte. The bench therefore drives each stimulus for one cycle starting at a falling edge and reads the outputs at the next falling edge, before any further stimulus. The early ready rise is checked on both sides of its edge. `rdy_o` must still be 0 exactly `PERIOD_CLKS-EARLY_CLKS` falling edges after the deposit and must be 1 one edge later. The settle lengths are checked the same way, as the count of ticks that pass without a load pulse before the one that carries it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    MD_CONT   = 3'b000,
    MD_SINGLE = 3'b001,
    MD_IDLE   = 3'b010,
    MD_PDOWN  = 3'b011,
    MD_ZS_CAL = 3'b100,
    MD_FS_CAL = 3'b101,
    MD_SYS_ZS = 3'b110,
    MD_SYS_FS = 3'b111
  } mode_e;

  localparam logic [2:0] GAIN_UNITY = 3'd0;
  localparam logic [2:0] GAIN_TOP   = 3'd7;

  function automatic logic mode_is_cal(mode_e m);
    return m[2];
  endfunction

  function automatic logic mode_runs(mode_e m);
    return !(m == MD_IDLE || m == MD_PDOWN);
  endfunction

endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned RST_PERIOD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             last_o
);

  logic [CNT_W-1:0] need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              need_q <= CNT_W'(RST_PERIOD);
    else if (restart_i)                       need_q <= load_i;
    else if (tick_i && need_q > CNT_W'(1))    need_q <= need_q - 1'b1;
  end

  assign last_o = (need_q == CNT_W'(1));

endmodule

// File: rtl/adc_seq_pretimer.sv
module adc_seq_pretimer #(
  parameter int unsigned PERIOD_CLKS = 40,
  parameter int unsigned EARLY_CLKS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic early_o
);

  localparam int unsigned CW = $clog2(PERIOD_CLKS + 1);
  localparam logic [CW-1:0] SAT  = CW'(PERIOD_CLKS);
  localparam logic [CW-1:0] TRIG = CW'(PERIOD_CLKS - EARLY_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q != SAT)  cnt_q <= cnt_q + 1'b1;
  end

  assign early_o = (cnt_q == TRIG);

endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags #(
  parameter int unsigned DATA_W = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_rdy_i,
  input  logic       set_rdy_i,
  input  logic       err_ld_i,
  input  logic       err_val_i,
  input  logic       err_clr_i,
  input  logic [2:0] chan_i,
  output logic       rdy_o,
  output logic [7:0] status_o
);

  localparam logic WIDE = (DATA_W > 16);

  logic rdy_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_q <= 1'b1;
    else if (clr_rdy_i) rdy_q <= 1'b0;
    else if (set_rdy_i) rdy_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_clr_i) err_q <= 1'b0;
    else if (err_ld_i)  err_q <= err_val_i;
  end

  assign rdy_o    = rdy_q;
  assign status_o = {rdy_q, err_q, 2'b00, WIDE, chan_i};

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W           = 24,
  parameter int unsigned PERIOD_CLKS      = 40,
  parameter int unsigned EARLY_CLKS       = 4,
  parameter int unsigned SETTLE_PERIODS   = 2,
  parameter int unsigned LONG_CAL_PERIODS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_i,
  input  logic              cfg_wr_i,
  input  logic [2:0]        chan_i,
  input  logic [2:0]        gain_i,
  input  logic              ext_ref_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              data_rd_i,
  output logic              data_ld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              coef_we_o,
  output logic              coef_sel_o,
  output logic [2:0]        coef_chan_o,
  output logic [DATA_W-1:0] coef_o,
  output logic [7:0]        status_o,
  output logic              rdy_o,
  output logic [2:0]        mode_o,
  output logic              pwr_down_o,
  output logic              filt_rst_o
);

  localparam int unsigned MAX_P = (LONG_CAL_PERIODS > SETTLE_PERIODS) ? LONG_CAL_PERIODS : SETTLE_PERIODS;
  localparam int unsigned CNT_W = $clog2(MAX_P + 1);

  mode_e            mode_q, mode_new, mode_tgt;
  logic [2:0]       chan_q;
  logic             fs_refuse, mode_acc, restart;
  logic             tk, last, hit, data_dep, cal_dep, early, early_ok;
  logic             clamp;
  logic [CNT_W-1:0] need_load;

  logic              data_ld_q, coef_we_q, coef_sel_q;
  logic [DATA_W-1:0] data_q, coef_q;
  logic [2:0]        coef_chan_q;

  assign mode_new  = mode_e'(mode_i);
  assign fs_refuse = mode_wr_i && (mode_new == MD_FS_CAL) && (gain_i == GAIN_TOP);
  assign mode_acc  = mode_wr_i && !fs_refuse;
  assign restart   = mode_acc || cfg_wr_i;
  assign mode_tgt  = mode_acc ? mode_new : mode_q;

  // internal full-scale is short only at unity gain on the external reference
  always_comb begin
    if (mode_tgt == MD_FS_CAL && !(gain_i == GAIN_UNITY && ext_ref_i))
      need_load = CNT_W'(LONG_CAL_PERIODS);
    else
      need_load = CNT_W'(SETTLE_PERIODS);
  end

  // writes take priority over a coincident tick
  assign tk       = tick_i && !restart && mode_runs(mode_q);
  assign hit      = tk && last;
  assign data_dep = hit && !mode_is_cal(mode_q);
  assign cal_dep  = hit && mode_is_cal(mode_q);
  assign clamp    = (&result_i) || (~|result_i);
  assign early_ok = early && (mode_q == MD_CONT) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   mode_q <= MD_CONT;
    else if (mode_acc)                             mode_q <= mode_new;
    else if (data_dep && mode_q == MD_SINGLE)      mode_q <= MD_PDOWN;
    else if (cal_dep)                              mode_q <= MD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chan_q <= '0;
    else if (restart) chan_q <= chan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_ld_q   <= 1'b0;
      coef_we_q   <= 1'b0;
      coef_sel_q  <= 1'b0;
      coef_chan_q <= '0;
      data_q      <= '0;
      coef_q      <= '0;
    end else begin
      data_ld_q <= data_dep;
      coef_we_q <= cal_dep;
      if (data_dep) data_q <= result_i;
      if (cal_dep) begin
        coef_q      <= result_i;
        coef_sel_q  <= mode_q[0];
        coef_chan_q <= chan_q;
      end
    end
  end

  adc_seq_settle #(
    .CNT_W      (CNT_W),
    .RST_PERIOD (SETTLE_PERIODS)
  ) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .load_i    (need_load),
    .tick_i    (tk),
    .last_o    (last)
  );

  adc_seq_pretimer #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .EARLY_CLKS  (EARLY_CLKS)
  ) u_pretimer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tick_i || restart),
    .early_o (early)
  );

  adc_seq_flags #(
    .DATA_W (DATA_W)
  ) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_rdy_i (data_dep || cal_dep),
    .set_rdy_i (restart || data_rd_i || early_ok),
    .err_ld_i  (data_dep),
    .err_val_i (clamp),
    .err_clr_i (mode_acc && mode_runs(mode_new)),
    .chan_i    (chan_q),
    .rdy_o     (rdy_o),
    .status_o  (status_o)
  );

  assign data_ld_o   = data_ld_q;
  assign data_o      = data_q;
  assign coef_we_o   = coef_we_q;
  assign coef_sel_o  = coef_sel_q;
  assign coef_chan_o = coef_chan_q;
  assign coef_o      = coef_q;
  assign mode_o      = mode_q;
  assign pwr_down_o  = (mode_q == MD_PDOWN);
  assign filt_rst_o  = !mode_runs(mode_q);

endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic [2:0] mode_i,
  input logic       cfg_wr_i,
  input logic [2:0] gain_i,
  input logic       tick_i,
  input logic       data_rd_i,
  input logic       data_ld_o,
  input logic       coef_we_o,
  input logic       rdy_o,
  input logic [2:0] mode_o,
  input logic       pwr_down_o,
  input logic       filt_rst_o
);

  AST_SINGLE_TO_PDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ld_o && $past(mode_o) == 3'b001 |-> pwr_down_o && !rdy_o); // R3

  AST_CAL_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> mode_o == 3'b010 && filt_rst_o && !rdy_o); // R5

  AST_CAL_START_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i[2] && !(mode_i == 3'b101 && gain_i == 3'd7) |=> rdy_o); // R5

  AST_FS_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i == 3'b101 && gain_i == 3'd7 && !tick_i && !cfg_wr_i
    |=> $stable(mode_o) && !coef_we_o); // R6

  AST_DEPOSIT_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ld_o |-> !rdy_o); // R7

  AST_READ_SETS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !tick_i |=> rdy_o); // R7

  AST_PDOWN_SETS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_i == 3'b011 |=> pwr_down_o && rdy_o); // R7

  AST_HELD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_o |=> !data_ld_o && !coef_we_o); // R10

endmodule

bind adc_mode_seq adc_mode_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_wr_i  (mode_wr_i),
  .mode_i     (mode_i),
  .cfg_wr_i   (cfg_wr_i),
  .gain_i     (gain_i),
  .tick_i     (tick_i),
  .data_rd_i  (data_rd_i),
  .data_ld_o  (data_ld_o),
  .coef_we_o  (coef_we_o),
  .rdy_o      (rdy_o),
  .mode_o     (mode_o),
  .pwr_down_o (pwr_down_o),
  .filt_rst_o (filt_rst_o)
);

// File: tb/adc_mode_seq_tb.sv
module adc_mode_seq_tb;

  localparam int unsigned DW = 24;
  localparam int unsigned PC = 40;
  localparam int unsigned EC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_wr_i = 1'b0, cfg_wr_i = 1'b0, ext_ref_i = 1'b1;
  logic [2:0]    mode_i = '0, chan_i = '0, gain_i = '0;
  logic          tick_i = 1'b0, data_rd_i = 1'b0;
  logic [DW-1:0] result_i = '0;
  logic          data_ld_o, coef_we_o, coef_sel_o, rdy_o, pwr_down_o, filt_rst_o;
  logic [DW-1:0] data_o, coef_o;
  logic [2:0]    coef_chan_o, mode_o;
  logic [7:0]    status_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  adc_mode_seq #(.DATA_W(DW), .PERIOD_CLKS(PC), .EARLY_CLKS(EC)) u_dut (
    .clk_i, .rst_ni, .mode_wr_i, .mode_i, .cfg_wr_i, .chan_i, .gain_i, .ext_ref_i,
    .tick_i, .result_i, .data_rd_i, .data_ld_o, .data_o, .coef_we_o, .coef_sel_o,
    .coef_chan_o, .coef_o, .status_o, .rdy_o, .mode_o, .pwr_down_o, .filt_rst_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_mode(input logic [2:0] m);
    mode_i = m; mode_wr_i = 1'b1;
    @(negedge clk_i); mode_wr_i = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] ch);
    chan_i = ch; cfg_wr_i = 1'b1;
    @(negedge clk_i); cfg_wr_i = 1'b0;
  endtask

  task automatic tick(input logic [DW-1:0] v);
    result_i = v; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic rd();
    data_rd_i = 1'b1;
    @(negedge clk_i); data_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode_o), 32'h0);
    chk("R1 rdy", 32'(rdy_o), 32'h1);
    chk("R1 pwr_down", 32'(pwr_down_o), 32'h0);
    chk("R1 filt_rst", 32'(filt_rst_o), 32'h0);
    chk("R9 status reset", 32'(status_o), 32'h88);
  endtask

  task automatic t_cont();
    wr_cfg(3'd5);
    chk("R7 cfg sets rdy", 32'(rdy_o), 32'h1);
    tick(24'h111111);
    chk("R2 first tick discarded", 32'(data_ld_o), 32'h0);
    tick(24'h222222);
    chk("R2 second tick loads", 32'(data_ld_o), 32'h1);
    chk("R2 data", 32'(data_o), 32'h222222);
    chk("R7 deposit clears rdy", 32'(rdy_o), 32'h0);
    chk("R9 status chan", 32'(status_o), 32'h0D);
    rd();
    chk("R7 read sets rdy", 32'(rdy_o), 32'h1);
    tick(24'h333333);
    chk("R2 continuous load", 32'(data_ld_o), 32'h1);
    chk("R2 continuous data", 32'(data_o), 32'h333333);
  endtask

  task automatic t_early();
    chk("R11 rdy low after deposit", 32'(rdy_o), 32'h0);
    repeat (PC - EC) @(negedge clk_i);
    chk("R11 rdy still low", 32'(rdy_o), 32'h0);
    @(negedge clk_i);
    chk("R11 rdy early rise", 32'(rdy_o), 32'h1);
  endtask

  task automatic t_err();
    tick('1);
    chk("R8 all ones err", 32'(status_o), 32'h4D);
    tick(24'h123456);
    chk("R8 clean clears err", 32'(status_o[6]), 32'h0);
    tick('0);
    chk("R8 all zeros err", 32'(status_o[6]), 32'h1);
    wr_mode(3'b000);
    chk("R8 start clears err", 32'(status_o[6]), 32'h0);
    chk("R7 mode write sets rdy", 32'(rdy_o), 32'h1);
    tick(24'h000444);
    chk("R2 restart after mode write", 32'(data_ld_o), 32'h0);
  endtask

  task automatic t_single();
    wr_mode(3'b001);
    chk("R3 single start rdy", 32'(rdy_o), 32'h1);
    tick(24'h0000AA);
    chk("R3 single settle", 32'(data_ld_o), 32'h0);
    tick(24'h0000BB);
    chk("R3 single load", 32'(data_ld_o), 32'h1);
    chk("R3 single data", 32'(data_o), 32'h0000BB);
    chk("R3 single to pdown", 32'(mode_o), 32'h3);
    chk("R3 pdown out", 32'(pwr_down_o), 32'h1);
    chk("R3 rdy low", 32'(rdy_o), 32'h0);
    repeat (60) @(negedge clk_i);
    chk("R3 rdy held low", 32'(rdy_o), 32'h0);
    tick(24'h0000CC);
    chk("R10 tick ignored in pdown", 32'(data_ld_o), 32'h0);
    rd();
    chk("R3 read sets rdy", 32'(rdy_o), 32'h1);
  endtask

  task automatic t_cal(input logic [2:0] m, input logic [2:0] g, input logic r,
                       input int n, input logic sel, input logic [2:0] ch,
                       input logic [DW-1:0] v);
    wr_cfg(ch);
    gain_i = g; ext_ref_i = r;
    wr_mode(m);
    chk("R5 cal start rdy", 32'(rdy_o), 32'h1);
    chk("R5 cal mode", 32'(mode_o), 32'(m));
    for (int i = 0; i < n - 1; i++) begin
      tick(v ^ 24'h00F0F0);
      chk("R4 cal still running", 32'(coef_we_o), 32'h0);
      chk("R4 rdy held", 32'(rdy_o), 32'h1);
    end
    tick(v);
    chk("R4 coef write", 32'(coef_we_o), 32'h1);
    chk("R4 coef sel", 32'(coef_sel_o), 32'(sel));
    chk("R4 coef chan", 32'(coef_chan_o), 32'(ch));
    chk("R4 coef value", 32'(coef_o), 32'(v));
    chk("R5 to idle", 32'(mode_o), 32'h2);
    chk("R5 rdy low", 32'(rdy_o), 32'h0);
    chk("R10 idle filt_rst", 32'(filt_rst_o), 32'h1);
    gain_i = '0; ext_ref_i = 1'b1;
  endtask

  task automatic t_refuse();
    gain_i = 3'd0;
    wr_mode(3'b000);
    tick(24'h000001);
    tick(24'h000002);
    chk("R6 setup load", 32'(data_ld_o), 32'h1);
    gain_i = 3'd7;
    wr_mode(3'b101);
    chk("R6 mode unchanged", 32'(mode_o), 32'h0);
    tick(24'h000777);
    chk("R6 no restart load", 32'(data_ld_o), 32'h1);
    chk("R6 no restart data", 32'(data_o), 32'h000777);
    chk("R6 no coef write", 32'(coef_we_o), 32'h0);
    gain_i = 3'd0;
  endtask

  task automatic t_pdown();
    wr_mode(3'b011);
    chk("R10 pdown out", 32'(pwr_down_o), 32'h1);
    chk("R7 pdown sets rdy", 32'(rdy_o), 32'h1);
    chk("R10 pdown filt_rst", 32'(filt_rst_o), 32'h1);
    tick(24'h000888);
    chk("R10 pdown ignores tick", 32'(data_ld_o), 32'h0);
    wr_mode(3'b000);
    chk("R10 leave pdown", 32'(pwr_down_o), 32'h0);
    tick(24'h000999);
    chk("R2 restart after pdown", 32'(data_ld_o), 32'h0);
    tick(24'h000AAA);
    chk("R2 load after pdown", 32'(data_ld_o), 32'h1);
  endtask

  task automatic t_idle();
    wr_mode(3'b010);
    chk("R10 idle filt_rst", 32'(filt_rst_o), 32'h1);
    chk("R10 idle no pdown", 32'(pwr_down_o), 32'h0);
    tick(24'h000BBB);
    chk("R10 idle ignores tick", 32'(data_ld_o), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cont();
    t_early();
    t_err();
    t_single();
    t_cal(3'b100, 3'd0, 1'b1, 2, 1'b0, 3'd1, 24'h0A0B0C);
    t_cal(3'b101, 3'd0, 1'b1, 2, 1'b1, 3'd2, 24'h1A1B1C);
    t_cal(3'b101, 3'd3, 1'b1, 4, 1'b1, 3'd3, 24'h2A2B2C);
    t_cal(3'b101, 3'd0, 1'b0, 4, 1'b1, 3'd4, 24'h3A3B3C);
    t_cal(3'b110, 3'd7, 1'b0, 2, 1'b0, 3'd6, 24'h4A4B4C);
    t_cal(3'b111, 3'd7, 1'b0, 2, 1'b1, 3'd7, 24'h5A5B5C);
    t_refuse();
    t_pdown();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule